// File: doc/BRIEF.md
# Lock-aware multi-master bus arbiter

This block decides which of several masters owns a shared bus. Master 0 is a processor-style master and the others are alternate masters. Each master has a request input and a grant output. The owner of the bus also drives two active-low indications: a continuous lock, which holds the bus for an indivisible read-modify-write sequence, and a lock-end marker, which flags the last transfer of that sequence.

Transfer boundaries come from a transfer-start strobe and a transfer-acknowledge strobe. Ownership changes only at an acknowledge or in an idle cycle. Masters that are not locked are served in round-robin order, starting from the master after the last owner. A preempt input withdraws grant at once, whatever the lock state. After grant is withdrawn, a new grant waits until the old owner's bus-busy indication is inactive, so two drivers never overlap on the bus.

Top module: `bus_lock_arbiter`

## Requirements
- R1: After a synchronous active-low reset every grant bit is 0, and at most one grant bit is ever 1.
- R2: From a cycle with no grant and bus_busy low, grant goes to the first requesting master found in the order last_owner+1, last_owner+2, ... wrapping modulo NUM_MASTERS. After reset the last owner counts as NUM_MASTERS-1, so master 0 is searched first.
- R3: While the owner drives its lock_n bit to 0 (0 = lock asserted, 1 = not locked), the grant stays with it across transfer boundaries and idle cycles, unless preempt is asserted or the lock-end rule of R4 applies.
- R4: A transfer during which the owner drives its lock_end_n bit to 0 (in the start cycle or any cycle up to the acknowledge) is the last one of the locked sequence. At its acknowledge the grant is released if another master requests, even while lock_n is still 0.
- R5: A cycle with preempt high while a grant is held makes grant all-zero on the next cycle, whatever the lock and transfer state. The locked state is cleared and is not resumed.
- R6: A new grant is issued only from a cycle with no grant and bus_busy low. A grant never moves directly from one master to another without at least one all-zero cycle in between.
- R7: The lock_n and lock_end_n bits of masters that do not hold the grant have no effect on grant.
- R8: Without preempt, grant changes only at a decision point: a cycle with xfer_ack high that ends the open transfer, or an idle cycle (no transfer open and xfer_start low). A cycle with xfer_start high and xfer_ack low never changes grant.
- R9: A lock-end transfer with no lock asserted at any point is a single-transfer locked operation. At its acknowledge the grant is released even if no other master requests.
- R10: With no lock in force, at a decision point the owner keeps the grant if it still requests and no other master requests. It loses the grant if it drops its request or another master requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NUM_MASTERS | Bus request, one bit per master |
| lock_n | input | NUM_MASTERS | Lock, active low, one bit per master |
| lock_end_n | input | NUM_MASTERS | Last locked transfer marker, active low, one bit per master |
| xfer_start | input | 1 | Transfer-start strobe from the current owner |
| xfer_ack | input | 1 | Transfer-acknowledge strobe ending the open transfer |
| bus_busy | input | 1 | High while a master still drives the bus |
| preempt | input | 1 | Forces the grant off regardless of lock |
| grant | output | NUM_MASTERS | Bus grant, at most one bit set |

## Verification
The bench builds the block with NUM_MASTERS = 4, the default. With that width the round-robin search wraps from master 3 back to master 0. A master that does not own the bus can drive its lock pin low while another master owns it, which shows that non-owner pins are ignored. Four masters also allow the picker to skip a non-requesting master between the owner and the next requester.

// File: rtl/bla_pkg.sv
// Package: shared types for the lock-aware bus arbiter.
// Assumes nothing beyond IEEE 1800-2017 synthesis subset.
package bla_pkg;

    // Ownership state of the arbiter
    typedef enum logic {
        ARB_IDLE  = 1'b0,   // no grant outstanding, may arbitrate
        ARB_OWNED = 1'b1    // one master holds the grant
    } arb_state_t;

endpackage

// File: rtl/bla_rr_picker.sv
// Round-robin picker: finds the first requesting master after the last
// owner, wrapping modulo N, with the last owner itself searched last.
// Assumes last_idx < N. Purely combinational.
module bla_rr_picker #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last_idx,
    output logic [IW-1:0] pick_idx,
    output logic          found
);

    // Search order starts at last_idx+1 and ends at last_idx
    always_comb begin
        pick_idx = '0;
        found    = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = int'(last_idx) + k;
            if (cand >= N) cand = cand - N;
            if (!found && req[cand]) begin
                found    = 1'b1;
                pick_idx = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/bla_xfer_tracker.sv
// Transfer tracker: follows start/acknowledge strobes of the owner and
// reports transfer boundaries and idle cycles. Assumes ack only ends a
// transfer that is open or starts in the same cycle.
module bla_xfer_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    input  logic ack,
    output logic in_xfer,
    output logic boundary,
    output logic idle_slot
);

    // Open-transfer flag: set by start, cleared by ack or by clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  in_xfer <= 1'b0;
        else if (start && !ack) in_xfer <= 1'b1;
        else if (ack)         in_xfer <= 1'b0;
    end

    // Boundary and idle decode for this cycle
    always_comb begin
        boundary  = ack && (in_xfer || start);
        idle_slot = !in_xfer && !start;
    end

endmodule

// File: rtl/bla_lock_tracker.sv
// Lock tracker: keeps the locked-sequence state of the current owner.
// Inputs lock_act/lend_act are already masked to the owner only.
// Assumes clear is raised whenever no grant is held or grant is dropped.
module bla_lock_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic lock_act,
    input  logic lend_act,
    input  logic start,
    input  logic in_xfer,
    input  logic boundary,
    output logic hold,
    output logic lone_eff
);

    logic last_q;   // lock-end seen during the open transfer
    logic seq_q;    // lock seen since the last sequence ended
    logic lend_now;
    logic last_eff;

    // Combine registered and current-cycle lock indications
    always_comb begin
        lend_now = lend_act && (start || in_xfer);
        last_eff = last_q || lend_now;
        hold     = lock_act && !last_eff;
        lone_eff = last_eff && !seq_q && !lock_act;
    end

    // Sequence state: cleared at a final boundary or on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            last_q <= 1'b0;
            seq_q  <= 1'b0;
        end else if (boundary) begin
            last_q <= 1'b0;
            seq_q  <= last_eff ? 1'b0 : (seq_q || lock_act);
        end else begin
            last_q <= last_q || lend_now;
            seq_q  <= seq_q || lock_act;
        end
    end

endmodule

// File: rtl/bus_lock_arbiter.sv
// Lock-aware multi-master bus arbiter. Grants one master at a time,
// holds the bus through locked sequences, releases on lock-end,
// supports forced preemption, and waits for bus_busy low before a
// new grant. Assumes strobes come from the current owner.
module bus_lock_arbiter
    import bla_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [NUM_MASTERS-1:0] lock_n,
    input  logic [NUM_MASTERS-1:0] lock_end_n,
    input  logic                   xfer_start,
    input  logic                   xfer_ack,
    input  logic                   bus_busy,
    input  logic                   preempt,
    output logic [NUM_MASTERS-1:0] grant
);

    localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
    localparam logic [IW-1:0] LAST_INIT = IW'(NUM_MASTERS - 1);

    arb_state_t            state;
    logic [NUM_MASTERS-1:0] grant_r;
    logic [IW-1:0]         last_owner;
    logic [IW-1:0]         pick_idx;
    logic                  pick_found;

    logic owned, lock_act, lend_act, owner_req, others_req;
    logic in_xfer, boundary, idle_slot, hold, lone_eff;
    logic decision, release_now, drop, trk_clear;
    logic [NUM_MASTERS-1:0] own_lock, own_lend;

    // Mask lock pins with the grant so only the owner's pins count
    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_mask
        assign own_lock[i] = grant_r[i] && !lock_n[i];
        assign own_lend[i] = grant_r[i] && !lock_end_n[i];
    end

    // Owner-related decode
    always_comb begin
        owned      = (state == ARB_OWNED);
        lock_act   = |own_lock;
        lend_act   = |own_lend;
        owner_req  = |(req & grant_r);
        others_req = |(req & ~grant_r);
    end

    bla_rr_picker #(.N(NUM_MASTERS), .IW(IW)) u_pick (
        .req      (req),
        .last_idx (last_owner),
        .pick_idx (pick_idx),
        .found    (pick_found)
    );

    bla_xfer_tracker u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (trk_clear),
        .start     (xfer_start),
        .ack       (xfer_ack),
        .in_xfer   (in_xfer),
        .boundary  (boundary),
        .idle_slot (idle_slot)
    );

    bla_lock_tracker u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (trk_clear),
        .lock_act (lock_act),
        .lend_act (lend_act),
        .start    (xfer_start),
        .in_xfer  (in_xfer),
        .boundary (boundary),
        .hold     (hold),
        .lone_eff (lone_eff)
    );

    // Release decision for the current owner
    always_comb begin
        decision    = boundary || idle_slot;
        release_now = owned && !preempt && decision && !hold &&
                      ((boundary && lone_eff) || !owner_req || others_req);
        drop        = owned && (preempt || release_now);
        trk_clear   = drop || !owned;
    end

    // Ownership state, grant register and last-owner pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ARB_IDLE;
            grant_r    <= '0;
            last_owner <= LAST_INIT;
        end else begin
            case (state)
                ARB_IDLE: begin
                    if (!bus_busy && pick_found) begin
                        state      <= ARB_OWNED;
                        grant_r    <= NUM_MASTERS'(1) << pick_idx;
                        last_owner <= pick_idx;
                    end
                end
                default: begin
                    if (drop) begin
                        state   <= ARB_IDLE;
                        grant_r <= '0;
                    end
                end
            endcase
        end
    end

    assign grant = grant_r;

endmodule

// File: rtl/bla_checker.sv
// Checker for bus_lock_arbiter, attached by bind. Observes ports only.
module bla_checker #(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_MASTERS-1:0] grant,
    input logic [NUM_MASTERS-1:0] lock_n,
    input logic                   xfer_start,
    input logic                   xfer_ack,
    input logic                   bus_busy,
    input logic                   preempt
);

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5
    preempt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preempt && grant != '0) |=> (grant == '0));

    // R6
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && bus_busy) |=> (grant == '0));

    // R6
    no_direct_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> (grant == $past(grant) || grant == '0));

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~lock_n) != '0 && !preempt && !xfer_ack) |=> $stable(grant));

    // R8
    mid_xfer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && xfer_start && !xfer_ack && !preempt) |=> $stable(grant));

endmodule

bind bus_lock_arbiter bla_checker #(.NUM_MASTERS(NUM_MASTERS)) u_bla_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .lock_n     (lock_n),
    .xfer_start (xfer_start),
    .xfer_ack   (xfer_ack),
    .bus_busy   (bus_busy),
    .preempt    (preempt)
);

// File: tb/bus_lock_arbiter_bench.sv
// Scoreboard bench: the driver pushes the expected grant after each edge,
// the monitor pops and compares it at the following falling edge.
module bus_lock_arbiter_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] lock_n = '1;
    logic [N-1:0] lock_end_n = '1;
    logic         xfer_start = 1'b0;
    logic         xfer_ack = 1'b0;
    logic         bus_busy = 1'b0;
    logic         preempt = 1'b0;
    logic [N-1:0] grant;

    typedef struct {
        logic [N-1:0] g;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_lock_arbiter #(.NUM_MASTERS(N)) u_bus_lock_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .lock_n     (lock_n),
        .lock_end_n (lock_end_n),
        .xfer_start (xfer_start),
        .xfer_ack   (xfer_ack),
        .bus_busy   (bus_busy),
        .preempt    (preempt),
        .grant      (grant)
    );

    // One clock of stimulus, then queue the grant expected after the edge
    task automatic step(input logic [N-1:0] rq, input logic [N-1:0] ln,
                        input logic [N-1:0] le, input logic st,
                        input logic ak, input logic bz, input logic pe,
                        input logic [N-1:0] exp_g, input string tag);
        exp_t e;
        @(negedge clk);
        req = rq; lock_n = ln; lock_end_n = le;
        xfer_start = st; xfer_ack = ak; bus_busy = bz; preempt = pe;
        @(posedge clk);
        e.g = exp_g;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (grant !== e.g) begin
                fails++;
                $display("FAIL %s: grant=%b expected=%b", e.tag, grant, e.g);
            end
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(4'b0000, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0000, "R1 reset");
        step(4'b0001, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0000, "R1 reset ignores req");
        @(negedge clk); rst_n = 1'b1;
        // R2: master 0 searched first after reset
        step(4'b0001, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0001, "R2 first grant to m0");
        // R10: lone requester keeps grant when idle
        step(4'b0001, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0001, "R10 owner keeps");
        // R8: start without ack holds grant although m2 requests
        step(4'b0101, 4'b1111, 4'b1111, 1, 0, 0, 0, 4'b0001, "R8 mid-transfer hold");
        step(4'b0101, 4'b1111, 4'b1111, 0, 1, 1, 0, 4'b0000, "R10 release at ack");
        // R6: no new grant while bus_busy is high
        step(4'b0101, 4'b1111, 4'b1111, 0, 0, 1, 0, 4'b0000, "R6 wait busy");
        step(4'b0101, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0100, "R2 rr to m2");
        step(4'b0101, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0000, "R10 release idle");
        step(4'b0101, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0001, "R2 rr wraps to m0");
        // R3: lock holds over idle and boundaries
        step(4'b0101, 4'b1110, 4'b1111, 0, 0, 0, 0, 4'b0001, "R3 lock idle");
        step(4'b0101, 4'b1110, 4'b1111, 1, 0, 0, 0, 4'b0001, "R3 lock start");
        step(4'b0101, 4'b1110, 4'b1111, 0, 1, 0, 0, 4'b0001, "R3 lock at ack");
        step(4'b0101, 4'b1110, 4'b1111, 0, 0, 0, 0, 4'b0001, "R3 lock between");
        // R4: lock-end in start cycle, release at its ack while lock still low
        step(4'b0101, 4'b1110, 4'b1110, 1, 0, 0, 0, 4'b0001, "R4 lock-end start");
        step(4'b0101, 4'b1110, 4'b1111, 0, 1, 0, 0, 4'b0000, "R4 release at last ack");
        step(4'b0101, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0100, "R2 rr to m2 after lock");
        // R7: non-owner m0 drives lock low, owner m2 still releases
        step(4'b0101, 4'b1110, 4'b1111, 0, 0, 0, 0, 4'b0000, "R7 non-owner lock ignored");
        step(4'b0101, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0001, "R2 m0 again");
        // R5: preempt during a locked transfer
        step(4'b0101, 4'b1110, 4'b1111, 1, 0, 0, 0, 4'b0001, "R3 locked transfer");
        step(4'b0101, 4'b1110, 4'b1111, 0, 0, 1, 1, 4'b0000, "R5 preempt drops grant");
        step(4'b0101, 4'b1110, 4'b1111, 0, 0, 1, 0, 4'b0000, "R6 busy after preempt");
        step(4'b0101, 4'b1110, 4'b1111, 0, 0, 0, 0, 4'b0100, "R5 lock not resumed");
        // R9: lone lock-end forces release with no other requester
        step(4'b0100, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0100, "R10 lone owner keeps");
        step(4'b0100, 4'b1111, 4'b1011, 1, 0, 0, 0, 4'b0100, "R9 lone lock-end start");
        step(4'b0100, 4'b1111, 4'b1111, 0, 1, 0, 0, 4'b0000, "R9 forced release");
        step(4'b0100, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0100, "R2 regrant m2");
        // R10: plain transfer with no other requester keeps grant
        step(4'b0100, 4'b1111, 4'b1111, 1, 0, 0, 0, 4'b0100, "R10 plain start");
        step(4'b0100, 4'b1111, 4'b1111, 0, 1, 0, 0, 4'b0100, "R10 plain ack keeps");
        step(4'b0000, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0000, "R10 drop request");
        step(4'b0000, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0000, "R1 stays empty");
        step(4'b1000, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b1000, "R2 grant m3");
        step(4'b1111, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0000, "R10 release to others");
        step(4'b1111, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0001, "R2 wrap m3 to m0");
        step(4'b0000, 4'b1111, 4'b1111, 0, 0, 0, 0, 4'b0000, "R10 final release");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule